// File: doc/BRIEF.md
# Background Memory Wiring Tester

This block is a bus master that checks the wiring of an external synchronous RAM while the rest of the system keeps using that RAM. Each start pulse makes it ask the system arbiter for the bus. Once granted, it runs one short critical section and then releases the bus. The section covers a whole sweep, a single probe pair, or a single cell. Every word it disturbs is read and held first and written back afterwards, so the memory contents are the same after each run.

In the sweep and pair modes it pairs a fixed base word with a partner at base plus a power-of-two offset, so each step exercises one address line. It writes a running test value to the base and the bitwise complement of that value to the partner, then reads both back. An open or shorted address line makes the two writes land on one word. A broken data line spoils at least one of the complementary values. In cell mode it walks a configured address window one word per start and writes two alternating-bit patterns to that word, which catches a failed bit inside a device.

Top module: `memwire_probe`

## Requirements
- R1: After grant, the first access of a sweep or pair run is a read of `BASE_ADDR`. The last write of the run is to `BASE_ADDR` with the word that read returned.
- R2: A sweep (`mode` 2'b00, and also 2'b11) runs `ADDR_W` steps with offsets 1, 2, 4 and so on, ending at 2^(ADDR_W-1). Step k writes, in order: value T+k to the base; ~(T+k) to base+2^k (modulo 2^ADDR_W); the saved partner word back to base+2^k. T is the test value at the start of the run.
- R3: With fault-free memory, every word of the RAM holds its original value after any run.
- R4: If a read-back differs from the expected value, `error` is set. It stays set across later clean runs until `err_clr` is high at a clock edge.
- R5: The test value is zero after reset, rises by one per completed step, and carries over from one start to the next.
- R6: `mem_en` is high only while `bus_gnt` is high. `bus_req` rises in the cycle after an accepted start, stays high through the final restore write, and is low in the following cycle, which is the `done` cycle.
- R7: Pair mode (`mode` 2'b01) runs exactly one step per start. The offset and the test value persist between starts, and the offset returns to 1 after 2^(ADDR_W-1). A sweep start resets the offset to 1.
- R8: Cell mode (`mode` 2'b10) tests one word per start. It reads the word, writes and verifies 0x5555 (bit i set for even i), writes and verifies 0xAAAA, writes the saved word back, then moves to the next address.
- R9: The cell address starts at `CELL_LO` after reset. It goes from `CELL_HI` back to `CELL_LO`. The run that tests `CELL_HI` raises `pass_done` for one cycle together with `done`.
- R10: `done` is a one-cycle pulse at the end of every run. `busy` is high from the cycle after an accepted start through the `done` cycle.
- R11: A start pulse while `busy` is high is ignored. `mode` is sampled only when a start is accepted.
- R12: After reset, `bus_req`, `mem_en`, `busy`, `done`, `error` and `pass_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| mode | input | 2 | 00/11 sweep, 01 single pair, 10 cell |
| err_clr | input | 1 | Clears the sticky error flag |
| bus_req | output | 1 | Bus request to the system arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| error | output | 1 | Sticky mismatch flag |
| pass_done | output | 1 | Cell window finished, pulses with done |

## Verification
The sweep is run against a healthy memory, a memory with one address line stuck low, and a memory with one data bit stuck low. The healthy run shows that the write order, values and restore are right. The address fault shows that complementary values on aliased words are caught. The data fault shows that a dead bit is caught whatever the address. Pair runs are repeated past the top offset to show that the cursor persists and wraps. Cell runs are walked across the whole window, once clean and once with a stuck bit, to separate the pattern check from the address advance and the wrap pulse.

// File: rtl/memwire_pkg.sv
package memwire_pkg;

   typedef enum logic [1:0] {
      MODE_SWEEP     = 2'b00,
      MODE_PAIR      = 2'b01,
      MODE_CELL      = 2'b10,
      MODE_SWEEP_ALT = 2'b11
   } run_mode_e;

   typedef enum logic [4:0] {
      ST_IDLE,
      ST_REQ,
      ST_RD_BASE,
      ST_RD_OFS,
      ST_WR_BASE,
      ST_WR_OFS,
      ST_VR_BASE,
      ST_VR_OFS,
      ST_RS_OFS,
      ST_RS_BASE,
      ST_C_RD,
      ST_C_W0,
      ST_C_R0,
      ST_C_W1,
      ST_C_R1,
      ST_C_RS,
      ST_REL
   } seq_state_e;

   // tag attached to a read, consumed when its data returns
   typedef enum logic [1:0] {
      CAP_NONE,
      CAP_BASE,
      CAP_OFS,
      CAP_CHK
   } cap_e;

endpackage

// File: rtl/memwire_cursor.sv
module memwire_cursor #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter logic [ADDR_W-1:0] CELL_LO = '0,
   parameter logic [ADDR_W-1:0] CELL_HI = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sweep_init,
   input  logic              step_adv,
   input  logic              cell_adv,
   output logic [ADDR_W-1:0] offset,
   output logic [DATA_W-1:0] tval,
   output logic [ADDR_W-1:0] cell_addr,
   output logic              cell_at_top
);

   localparam logic [ADDR_W-1:0] OFS_FIRST = ADDR_W'(1);

   logic [ADDR_W-1:0] ofs_rot;

   assign ofs_rot     = {offset[ADDR_W-2:0], offset[ADDR_W-1]};
   assign cell_at_top = (cell_addr == CELL_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         offset <= OFS_FIRST;
         tval   <= '0;
      end else if (sweep_init) begin
         offset <= OFS_FIRST;
      end else if (step_adv) begin
         offset <= ofs_rot;
         tval   <= tval + DATA_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cell_addr <= CELL_LO;
      end else if (cell_adv) begin
         cell_addr <= cell_at_top ? CELL_LO : cell_addr + ADDR_W'(1);
      end
   end

endmodule

// File: rtl/memwire_verify.sv
module memwire_verify
   import memwire_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  cap_e              cap,
   input  logic [DATA_W-1:0] exp_val,
   input  logic [DATA_W-1:0] rdata,
   input  logic              err_clr,
   output logic [DATA_W-1:0] save_base,
   output logic [DATA_W-1:0] save_ofs,
   output logic              error
);

   cap_e              tag_q;
   logic [DATA_W-1:0] exp_q;
   logic              miss;

   assign miss = (tag_q == CAP_CHK) && (rdata != exp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q <= CAP_NONE;
         exp_q <= '0;
      end else begin
         tag_q <= cap;
         exp_q <= exp_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         save_base <= '0;
         save_ofs  <= '0;
      end else begin
         if (tag_q == CAP_BASE) save_base <= rdata;
         if (tag_q == CAP_OFS)  save_ofs  <= rdata;
      end
   end

   // a new mismatch wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       error <= 1'b0;
      else if (miss)    error <= 1'b1;
      else if (err_clr) error <= 1'b0;
   end

endmodule

// File: rtl/memwire_probe.sv
module memwire_probe
   import memwire_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
   parameter logic [ADDR_W-1:0] CELL_LO = '0,
   parameter logic [ADDR_W-1:0] CELL_HI = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic              err_clr,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              error,
   output logic              pass_done
);

   if (ADDR_W < 2) begin : g_chk_aw
      $error("memwire_probe: ADDR_W must be at least 2");
   end
   if ((DATA_W < 2) || (DATA_W % 2 != 0)) begin : g_chk_dw
      $error("memwire_probe: DATA_W must be even and at least 2");
   end
   if (CELL_LO > CELL_HI) begin : g_chk_cell
      $error("memwire_probe: CELL_LO above CELL_HI");
   end

   // alternating-bit cell patterns
   logic [DATA_W-1:0] pat_lo;
   logic [DATA_W-1:0] pat_hi;
   for (genvar i = 0; i < DATA_W; i++) begin : g_pat
      assign pat_lo[i] = ((i % 2) == 0);
   end
   assign pat_hi = ~pat_lo;

   seq_state_e        st_q, st_d;
   run_mode_e         mode_q;
   logic              wrap_q;

   logic              sweep_init, step_adv, cell_adv;
   logic [ADDR_W-1:0] offset, cell_addr;
   logic [DATA_W-1:0] tval;
   logic              cell_at_top;

   cap_e              cap;
   logic [DATA_W-1:0] exp_val;
   logic [DATA_W-1:0] save_base, save_ofs;

   logic [ADDR_W-1:0] addr_base, addr_pair;
   logic              last_step;

   assign addr_base = BASE_ADDR;
   assign addr_pair = BASE_ADDR + offset;
   assign last_step = (mode_q == MODE_PAIR) || offset[ADDR_W-1];

   memwire_cursor #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CELL_LO(CELL_LO),
      .CELL_HI(CELL_HI)
   ) u_cursor (
      .clk        (clk),
      .rst_n      (rst_n),
      .sweep_init (sweep_init),
      .step_adv   (step_adv),
      .cell_adv   (cell_adv),
      .offset     (offset),
      .tval       (tval),
      .cell_addr  (cell_addr),
      .cell_at_top(cell_at_top)
   );

   memwire_verify #(
      .DATA_W(DATA_W)
   ) u_verify (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (cap),
      .exp_val  (exp_val),
      .rdata    (mem_rdata),
      .err_clr  (err_clr),
      .save_base(save_base),
      .save_ofs (save_ofs),
      .error    (error)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         mode_q <= MODE_SWEEP;
         wrap_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && start) mode_q <= run_mode_e'(mode);
         if (st_q == ST_C_RS)          wrap_q <= cell_at_top;
         else if (st_q == ST_REL)      wrap_q <= 1'b0;
      end
   end

   always_comb begin
      st_d       = st_q;
      mem_en     = 1'b0;
      mem_we     = 1'b0;
      mem_addr   = addr_base;
      mem_wdata  = '0;
      cap        = CAP_NONE;
      exp_val    = '0;
      sweep_init = 1'b0;
      step_adv   = 1'b0;
      cell_adv   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               st_d       = ST_REQ;
               sweep_init = (mode == MODE_SWEEP) || (mode == MODE_SWEEP_ALT);
            end
         end
         ST_REQ: begin
            if (bus_gnt) st_d = (mode_q == MODE_CELL) ? ST_C_RD : ST_RD_BASE;
         end
         ST_RD_BASE: begin
            mem_en = 1'b1;
            cap    = CAP_BASE;
            st_d   = ST_RD_OFS;
         end
         ST_RD_OFS: begin
            mem_en   = 1'b1;
            mem_addr = addr_pair;
            cap      = CAP_OFS;
            st_d     = ST_WR_BASE;
         end
         ST_WR_BASE: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = tval;
            st_d      = ST_WR_OFS;
         end
         ST_WR_OFS: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = addr_pair;
            mem_wdata = ~tval;
            st_d      = ST_VR_BASE;
         end
         ST_VR_BASE: begin
            mem_en  = 1'b1;
            cap     = CAP_CHK;
            exp_val = tval;
            st_d    = ST_VR_OFS;
         end
         ST_VR_OFS: begin
            mem_en   = 1'b1;
            mem_addr = addr_pair;
            cap      = CAP_CHK;
            exp_val  = ~tval;
            st_d     = ST_RS_OFS;
         end
         ST_RS_OFS: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = addr_pair;
            mem_wdata = save_ofs;
            step_adv  = 1'b1;
            st_d      = last_step ? ST_RS_BASE : ST_RD_OFS;
         end
         ST_RS_BASE: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = save_base;
            st_d      = ST_REL;
         end
         ST_C_RD: begin
            mem_en   = 1'b1;
            mem_addr = cell_addr;
            cap      = CAP_BASE;
            st_d     = ST_C_W0;
         end
         ST_C_W0: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cell_addr;
            mem_wdata = pat_lo;
            st_d      = ST_C_R0;
         end
         ST_C_R0: begin
            mem_en   = 1'b1;
            mem_addr = cell_addr;
            cap      = CAP_CHK;
            exp_val  = pat_lo;
            st_d     = ST_C_W1;
         end
         ST_C_W1: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cell_addr;
            mem_wdata = pat_hi;
            st_d      = ST_C_R1;
         end
         ST_C_R1: begin
            mem_en   = 1'b1;
            mem_addr = cell_addr;
            cap      = CAP_CHK;
            exp_val  = pat_hi;
            st_d     = ST_C_RS;
         end
         ST_C_RS: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cell_addr;
            mem_wdata = save_base;
            cell_adv  = 1'b1;
            st_d      = ST_REL;
         end
         ST_REL: begin
            st_d = ST_IDLE;
         end
         default: begin
            st_d = ST_IDLE;
         end
      endcase
   end

   assign busy      = (st_q != ST_IDLE);
   assign bus_req   = (st_q != ST_IDLE) && (st_q != ST_REL);
   assign done      = (st_q == ST_REL);
   assign pass_done = (st_q == ST_REL) && wrap_q;

endmodule

// File: rtl/memwire_probe_chk.sv
module memwire_probe_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic err_clr,
   input logic bus_req,
   input logic bus_gnt,
   input logic mem_en,
   input logic mem_we,
   input logic busy,
   input logic done,
   input logic error,
   input logic pass_done
);

   p_access_granted_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> bus_gnt);

   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_en && !bus_req));

   p_req_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_req) |-> done);

   p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   p_restore_before_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(mem_en && mem_we));

   p_pass_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |-> done);

   p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (error && !err_clr) |=> error);

endmodule

bind memwire_probe memwire_probe_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .err_clr  (err_clr),
   .bus_req  (bus_req),
   .bus_gnt  (bus_gnt),
   .mem_en   (mem_en),
   .mem_we   (mem_we),
   .busy     (busy),
   .done     (done),
   .error    (error),
   .pass_done(pass_done)
);

// File: tb/memwire_probe_test.sv
module memwire_probe_test;

   localparam int AW = 10;
   localparam int DW = 16;
   localparam int MEMN = 1 << AW;
   localparam logic [AW-1:0] BASE = 10'h010;
   localparam logic [AW-1:0] CLO  = 10'h3FC;
   localparam logic [AW-1:0] CHI  = 10'h3FF;
   localparam int LOGN = 4096;
   localparam int NONE = 31;

   // {mode[1:0], addr fault bit[4:0], data fault bit[4:0], expect error}
   localparam int NROW = 8;
   localparam logic [12:0] ROWS [NROW] = '{
      {2'b00, 5'd31, 5'd31, 1'b0},
      {2'b11, 5'd31, 5'd31, 1'b0},
      {2'b00, 5'd3,  5'd31, 1'b1},
      {2'b00, 5'd31, 5'd7,  1'b1},
      {2'b01, 5'd31, 5'd31, 1'b0},
      {2'b01, 5'd31, 5'd31, 1'b0},
      {2'b10, 5'd31, 5'd31, 1'b0},
      {2'b10, 5'd31, 5'd0,  1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [1:0] mode = 2'b00;
   logic err_clr = 1'b0;
   logic bus_req, bus_gnt, mem_en, mem_we, busy, done, error, pass_done;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;

   always #4 clk = ~clk;

   memwire_probe #(
      .ADDR_W(AW), .DATA_W(DW), .BASE_ADDR(BASE), .CELL_LO(CLO), .CELL_HI(CHI)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .err_clr(err_clr),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .error(error), .pass_done(pass_done)
   );

   // ---------------- memory, arbiter and access log ----------------
   logic [DW-1:0] ram [MEMN];
   logic [DW-1:0] rd_q = '0;
   logic          gnt_q = 1'b0;
   logic          reload = 1'b0;
   int            af = -1;
   int            df = -1;
   int            viol = 0;
   int            nlog = 0;
   logic          lw [LOGN];
   logic [AW-1:0] la [LOGN];
   logic [DW-1:0] ld [LOGN];

   function automatic logic [DW-1:0] iv(int i);
      return DW'((i * 40503) ^ 16'h3C5A);
   endfunction

   function automatic logic [AW-1:0] phys(logic [AW-1:0] a);
      if (af < 0) return a;
      return a & ~(AW'(1) << af);
   endfunction

   function automatic logic [DW-1:0] dmask();
      if (df < 0) return '1;
      return ~(DW'(1) << df);
   endfunction

   assign bus_gnt   = gnt_q;
   assign mem_rdata = rd_q;

   always @(posedge clk) begin
      gnt_q <= bus_req;
      if (reload) begin
         for (int i = 0; i < MEMN; i++) ram[i] <= iv(i);
      end else if (mem_en) begin
         if (mem_we) ram[phys(mem_addr)] <= mem_wdata;
         else        rd_q <= ram[phys(mem_addr)] & dmask();
      end
      if (mem_en && !bus_gnt) viol <= viol + 1;
      if (mem_en && nlog < LOGN) begin
         lw[nlog] <= mem_we;
         la[nlog] <= mem_addr;
         ld[nlog] <= mem_wdata;
         nlog     <= nlog + 1;
      end
   end

   // ---------------- checking ----------------
   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0] tv_m = '0;   // model test value
   int            pofs_m = 0;  // model pair offset index
   logic [AW-1:0] cell_m = CLO;
   logic [AW-1:0] wa [64];
   logic [DW-1:0] wd [64];
   int            wn;
   int            s0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
   end

   task automatic do_reload();
      @(negedge clk) reload = 1'b1;
      @(negedge clk) reload = 1'b0;
   endtask

   task automatic clear_err();
      @(negedge clk) err_clr = 1'b1;
      @(negedge clk) err_clr = 1'b0;
   endtask

   // pulse start, check busy next cycle (R10), wait for done
   task automatic launch(logic [1:0] m);
      int cyc;
      @(negedge clk);
      s0 = nlog;
      start = 1'b1;
      mode  = m;
      @(negedge clk);
      start = 1'b0;
      mode  = 2'b10;
      chk("R10 busy after start", busy, 1'b1);
      cyc = 0;
      while (!done && cyc < 4000) begin
         @(negedge clk);
         cyc++;
      end
      chk("R10 done seen", done, 1'b1);
      chk("R6 req low in done cycle", bus_req, 1'b0);
      chk("R6 no access without grant", viol, 0);
   endtask

   task automatic gather_writes();
      wn = 0;
      for (int i = s0; i < nlog; i++) begin
         if (lw[i] && wn < 64) begin
            wa[wn] = la[i];
            wd[wn] = ld[i];
            wn++;
         end
      end
   endtask

   task automatic check_ram(string req);
      int bad = 0;
      for (int i = 0; i < MEMN; i++) if (ram[i] !== iv(i)) bad++;
      chk(req, bad, 0);
   endtask

   task automatic check_sweep(bit faulted);
      int bad = 0;
      gather_writes();
      chk("R1 first access reads base", {lw[s0], la[s0]}, {1'b0, BASE});
      chk("R2 sweep write count", wn, 3 * AW + 1);
      for (int k = 0; k < AW; k++) begin
         logic [AW-1:0] pa;
         pa = BASE + (AW'(1) << k);
         if (wa[3*k] !== BASE || wd[3*k] !== DW'(tv_m + k)) bad++;
         if (wa[3*k+1] !== pa || wd[3*k+1] !== ~DW'(tv_m + k)) bad++;
         if (wa[3*k+2] !== pa) bad++;
         if (!faulted && wd[3*k+2] !== iv(int'(pa))) bad++;
      end
      chk("R2 R5 sweep write sequence", bad, 0);
      chk("R1 final restore address", wa[3*AW], BASE);
      if (!faulted) begin
         chk("R1 final restore data", wd[3*AW], iv(int'(BASE)));
         check_ram("R3 memory unchanged after sweep");
      end
      chk("R9 no pass pulse on sweep", pass_done, 1'b0);
      tv_m   = tv_m + DW'(AW);
      pofs_m = 0;
   endtask

   task automatic check_pair();
      logic [AW-1:0] pa;
      pa = BASE + (AW'(1) << pofs_m);
      gather_writes();
      chk("R7 pair write count", wn, 4);
      chk("R7 R5 pair base write", {wa[0], wd[0]}, {BASE, tv_m});
      chk("R7 pair partner write", {wa[1], wd[1]}, {pa, ~tv_m});
      chk("R1 pair restores base", {wa[3], wd[3]}, {BASE, iv(int'(BASE))});
      check_ram("R3 memory unchanged after pair");
      tv_m   = tv_m + 1'b1;
      pofs_m = (pofs_m + 1) % AW;
   endtask

   task automatic check_cell(bit faulted);
      gather_writes();
      chk("R8 cell first access reads cell", {lw[s0], la[s0]}, {1'b0, cell_m});
      chk("R8 cell write count", wn, 3);
      chk("R8 cell pattern 5555", {wa[0], wd[0]}, {cell_m, 16'h5555});
      chk("R8 cell pattern AAAA", {wa[1], wd[1]}, {cell_m, 16'hAAAA});
      chk("R8 cell restore address", wa[2], cell_m);
      if (!faulted) begin
         chk("R8 cell restore data", wd[2], iv(int'(cell_m)));
         check_ram("R3 memory unchanged after cell");
      end
      chk("R9 pass pulse at window top", pass_done, (cell_m == CHI));
      cell_m = (cell_m == CHI) ? CLO : cell_m + 1'b1;
   endtask

   initial begin
      // ---------------- reset state (R12) ----------------
      reload = 1'b1;
      repeat (3) @(negedge clk);
      reload = 1'b0;
      rst_n  = 1'b1;
      @(negedge clk);
      chk("R12 reset bus_req", bus_req, 1'b0);
      chk("R12 reset mem_en", mem_en, 1'b0);
      chk("R12 reset busy", busy, 1'b0);
      chk("R12 reset done", done, 1'b0);
      chk("R12 reset error", error, 1'b0);
      chk("R12 reset pass_done", pass_done, 1'b0);

      // ---------------- vector table ----------------
      for (int r = 0; r < NROW; r++) begin
         logic [1:0] m;
         bit faulted;
         m  = ROWS[r][12:11];
         af = (ROWS[r][10:6] == NONE) ? -1 : int'(ROWS[r][10:6]);
         df = (ROWS[r][5:1]  == NONE) ? -1 : int'(ROWS[r][5:1]);
         faulted = (af >= 0) || (df >= 0);
         launch(m);
         chk("R4 error flag after run", error, ROWS[r][0]);
         if (m == 2'b01)      check_pair();
         else if (m == 2'b10) check_cell(faulted);
         else                 check_sweep(faulted);
         @(negedge clk);
         chk("R10 done lasts one cycle", done, 1'b0);
         af = -1;
         df = -1;
         if (faulted) begin
            do_reload();
            clear_err();
            chk("R4 clear drops error", error, 1'b0);
         end
      end

      // ---------------- sticky error (R4) ----------------
      af = 5;
      launch(2'b00);
      chk("R4 address line fault detected", error, 1'b1);
      tv_m   = tv_m + DW'(AW);
      pofs_m = 0;
      af = -1;
      do_reload();
      launch(2'b00);
      check_sweep(1'b0);
      chk("R4 error stays set over clean run", error, 1'b1);
      clear_err();
      chk("R4 error cleared", error, 1'b0);

      // ---------------- start while busy (R11) ----------------
      @(negedge clk);
      s0 = nlog;
      start = 1'b1;
      mode  = 2'b00;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      start = 1'b1;
      mode  = 2'b10;
      @(negedge clk);
      start = 1'b0;
      begin
         int cyc = 0;
         while (!done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
         end
      end
      check_sweep(1'b0);
      repeat (3) @(negedge clk);
      chk("R11 second start ignored, engine idle", busy, 1'b0);

      // ---------------- pair cursor persistence and wrap (R7) ----------------
      for (int j = 0; j < AW + 2; j++) begin
         launch(2'b01);
         check_pair();
      end

      // ---------------- cell window walk and wrap (R9) ----------------
      for (int j = 0; j < 5; j++) begin
         launch(2'b10);
         check_cell(1'b0);
      end
      chk("R4 clean runs leave error low", error, 1'b0);

      summary();
   end

endmodule